// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block decides which of several hardware thread contexts owns a coarse-grained multithreaded pipeline. Only one context issues at a time. A policy input picks one of two switching rules. In time-slice mode, the running context gives up the pipeline after a fixed number of issue cycles. In miss mode, it gives up the pipeline as soon as it reports a long-latency (second-level) cache miss. Each context has its own register bank, so a switch only steers the bank select and announces the change. The state of the context that leaves stays in its own bank.

The controller keeps a ready/waiting flag for each context. A context that misses waits until memory returns a refill-done pulse tagged with its ID. The next owner is found in round-robin order. The search starts at the context after the current one and skips any context that is waiting. Every switch raises a one-cycle pulse, which the pipeline uses to flush and to save context. The pulse is followed by a short penalty during which issue stays disabled. If no other context is ready, the controller keeps the current owner and does not pulse. If that owner is itself waiting, the pipeline idles until a refill arrives.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: After reset, context 0 is active, every context is ready, `switch_pulse` is 0, `issue_en` is 1 and the time-slice count starts from zero.
- R2: `bank_sel` is always one-hot, and bit i is set exactly when `active_tid` equals i.
- R3: With `policy_sel`=0 (time-slice mode), a context issues for exactly QUANTUM cycles (default 16). In the cycle after its last issue cycle, the next ready context becomes active.
- R4: With `policy_sel`=1 (miss mode), a `miss_valid` seen in a cycle with `issue_en`=1 marks the running context waiting. In the next cycle the controller switches away, with `active_tid` changing and `switch_pulse` high in that same cycle.
- R5: A switch holds `switch_pulse` high for exactly one cycle. `issue_en` is low in the pulse cycle and in the PENALTY (default 2) cycles after it, then returns high.
- R6: The new owner is the first ready context when counting up from the current ID plus one, wrapping past the highest ID. Waiting contexts are skipped, and `active_tid` changes only in a pulse cycle.
- R7: When no other context is ready at a switch point, `active_tid` stays the same and no pulse is raised. If the current context is waiting, `issue_en` stays 0 (idle). Otherwise it keeps issuing and starts a fresh time slice.
- R8: `refill_valid` with `refill_tid`=i marks context i ready. An idle controller then either switches to a refilled context or resumes its own. This happens in the cycle after the refill, and a refill of the idle owner itself causes no pulse.
- R9: `miss_valid` has no effect while `issue_en` is 0, or while `policy_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 1 | 0 = time-slice switching, 1 = switch on miss |
| miss_valid | input | 1 | Running context reports a long-latency cache miss |
| refill_valid | input | 1 | Memory reports a refill done for `refill_tid` |
| refill_tid | input | TID_W | Context whose refill completed |
| active_tid | output | TID_W | Context that owns the pipeline |
| switch_pulse | output | 1 | One-cycle pulse in the first cycle of a new owner |
| issue_en | output | 1 | The owner may issue this cycle |
| bank_sel | output | NUM_CTX | One-hot register bank select |

## Verification
The bench walks the miss-mode rotation until every context waits, and checks three cases there. First, the idle owner must not pulse; a design that switches to a waiting context would show a pulse. Second, a refill of another context must start a switch at once. Third, a refill of the idle owner must resume it silently; a design that misses this would stay idle forever or raise a spurious pulse. It sends a miss during the penalty window and in time-slice mode, where a design that honours it would drop `issue_en` later. It also counts issue and stall cycles for each time slice. This catches an off-by-one slice length or a penalty of the wrong length, as well as a rotation that fails to wrap from the top ID back to 0.

// File: rtl/ctx_sw_pkg.sv
package ctx_sw_pkg;

  typedef enum logic {
    POL_SLICE = 1'b0,
    POL_MISS  = 1'b1
  } sw_policy_e;

  // Position reached by stepping 'step' places round a ring of 'n' slots.
  function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                           int unsigned n);
    return (base + step) % n;
  endfunction

  // Next value of a down counter that stops at zero, or reload on request.
  function automatic int unsigned down_or_load(int unsigned cur, bit load,
                                               int unsigned load_val);
    if (load)      return load_val;
    if (cur != 0)  return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/ctx_ready_track.sv
module ctx_ready_track #(
  parameter int NUM_CTX = 4,
  parameter int TID_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               refill_valid,
  input  logic [TID_W-1:0]   refill_tid,
  input  logic               miss_take,
  input  logic [TID_W-1:0]   cur_tid,
  output logic [NUM_CTX-1:0] ready_q,
  output logic [NUM_CTX-1:0] ready_eff
);

  // Refill sets, a taken miss on the owner clears; the clear wins.
  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic wake, sleep;
    assign wake  = refill_valid && (refill_tid == TID_W'(g));
    assign sleep = miss_take && (cur_tid == TID_W'(g));
    assign ready_eff[g] = (ready_q[g] | wake) & ~sleep;

    always_ff @(posedge clk) begin
      if (!rst_n) ready_q[g] <= 1'b1;
      else        ready_q[g] <= ready_eff[g];
    end
  end

endmodule

// File: rtl/ctx_rr_picker.sv
module ctx_rr_picker #(
  parameter int NUM_CTX = 4,
  parameter int TID_W   = 2
) (
  input  logic [NUM_CTX-1:0] ready_eff,
  input  logic [TID_W-1:0]   cur_tid,
  output logic               found,
  output logic [TID_W-1:0]   pick_tid
);
  import ctx_sw_pkg::*;

  // Offsets NUM_CTX down to 1: the smallest offset that is ready wins.
  // Offset NUM_CTX is the current context itself, so it is the last resort.
  always_comb begin
    found    = 1'b0;
    pick_tid = cur_tid;
    for (int k = NUM_CTX; k >= 1; k--) begin
      logic [TID_W-1:0] cand;
      cand = TID_W'(ring_add(32'(cur_tid), k, NUM_CTX));
      if (ready_eff[cand]) begin
        found    = 1'b1;
        pick_tid = cand;
      end
    end
  end

endmodule

// File: rtl/ctx_slice_ctr.sv
module ctx_slice_ctr #(
  parameter int QUANTUM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic at_limit
);
  localparam int CNT_W = $clog2(QUANTUM + 1);

  logic [CNT_W-1:0] cnt_q;

  assign at_limit = (cnt_q == CNT_W'(QUANTUM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl #(
  parameter int NUM_CTX = 4,
  parameter int QUANTUM = 16,
  parameter int PENALTY = 2,
  parameter int TID_W   = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               policy_sel,
  input  logic               miss_valid,
  input  logic               refill_valid,
  input  logic [TID_W-1:0]   refill_tid,
  output logic [TID_W-1:0]   active_tid,
  output logic               switch_pulse,
  output logic               issue_en,
  output logic [NUM_CTX-1:0] bank_sel
);
  import ctx_sw_pkg::*;

  localparam int PEN_W   = $clog2(PENALTY + 2);
  localparam int PEN_RLD = PENALTY + 1;  // pulse cycle plus penalty cycles

  sw_policy_e           policy;
  logic [TID_W-1:0]     cur_q;
  logic                 pulse_q;
  logic [PEN_W-1:0]     pen_q;
  logic [NUM_CTX-1:0]   ready_q, ready_eff;

  // Named internal events.
  logic                 issuing;
  logic                 miss_take;
  logic                 slice_limit;
  logic                 slice_expire;
  logic                 idle_wait;
  logic                 decide;
  logic                 found;
  logic [TID_W-1:0]     pick_tid;
  logic                 do_switch;

  assign policy       = sw_policy_e'(policy_sel);
  assign issuing      = (pen_q == '0) && ready_q[cur_q];
  assign miss_take    = (policy == POL_MISS) && miss_valid && issuing;
  assign slice_expire = (policy == POL_SLICE) && issuing && slice_limit;
  assign idle_wait    = (pen_q == '0) && !ready_q[cur_q];
  assign decide       = miss_take || slice_expire || idle_wait;
  assign do_switch    = decide && found && (pick_tid != cur_q);

  ctx_ready_track #(.NUM_CTX(NUM_CTX), .TID_W(TID_W)) i_ready (
    .clk          (clk),
    .rst_n        (rst_n),
    .refill_valid (refill_valid),
    .refill_tid   (refill_tid),
    .miss_take    (miss_take),
    .cur_tid      (cur_q),
    .ready_q      (ready_q),
    .ready_eff    (ready_eff)
  );

  ctx_rr_picker #(.NUM_CTX(NUM_CTX), .TID_W(TID_W)) i_pick (
    .ready_eff (ready_eff),
    .cur_tid   (cur_q),
    .found     (found),
    .pick_tid  (pick_tid)
  );

  ctx_slice_ctr #(.QUANTUM(QUANTUM)) i_slice (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    ((policy == POL_MISS) || do_switch || slice_expire),
    .count_en (issuing),
    .at_limit (slice_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      pulse_q <= 1'b0;
      pen_q   <= '0;
    end else begin
      if (do_switch) cur_q <= pick_tid;
      pulse_q <= do_switch;
      pen_q   <= PEN_W'(down_or_load(32'(pen_q), do_switch, PEN_RLD));
    end
  end

  assign active_tid   = cur_q;
  assign switch_pulse = pulse_q;
  assign issue_en     = issuing;

  for (genvar b = 0; b < NUM_CTX; b++) begin : g_bank
    assign bank_sel[b] = (cur_q == TID_W'(b));
  end

endmodule

// File: rtl/ctx_switch_ctrl_chk.sv
module ctx_switch_ctrl_chk #(
  parameter int NUM_CTX = 4,
  parameter int TID_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               policy_sel,
  input logic               miss_valid,
  input logic [TID_W-1:0]   active_tid,
  input logic               switch_pulse,
  input logic               issue_en,
  input logic [NUM_CTX-1:0] bank_sel,
  input logic               do_switch
);

  assert_bank_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(bank_sel) && bank_sel[active_tid]);

  assert_miss_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_sel && miss_valid && issue_en) |=> (switch_pulse || !issue_en));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !switch_pulse);

  assert_penalty_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !issue_en);

  assert_owner_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_pulse |-> $stable(active_tid));

  assert_slice_miss_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!policy_sel && miss_valid && issue_en && !do_switch) |=> issue_en);

endmodule

bind ctx_switch_ctrl ctx_switch_ctrl_chk #(.NUM_CTX(NUM_CTX), .TID_W(TID_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .policy_sel   (policy_sel),
  .miss_valid   (miss_valid),
  .active_tid   (active_tid),
  .switch_pulse (switch_pulse),
  .issue_en     (issue_en),
  .bank_sel     (bank_sel),
  .do_switch    (do_switch)
);

// File: tb/test_ctx_switch_ctrl.sv
module test_ctx_switch_ctrl;

  localparam int NUM_CTX = 4;
  localparam int QUANTUM = 16;
  localparam int PENALTY = 2;
  localparam int TID_W   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               policy_sel = 1'b0;
  logic               miss_valid = 1'b0;
  logic               refill_valid = 1'b0;
  logic [TID_W-1:0]   refill_tid = '0;
  logic [TID_W-1:0]   active_tid;
  logic               switch_pulse;
  logic               issue_en;
  logic [NUM_CTX-1:0] bank_sel;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  ctx_switch_ctrl #(.NUM_CTX(NUM_CTX), .QUANTUM(QUANTUM), .PENALTY(PENALTY))
    i_ctx_switch_ctrl (
      .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .miss_valid(miss_valid),
      .refill_valid(refill_valid), .refill_tid(refill_tid), .active_tid(active_tid),
      .switch_pulse(switch_pulse), .issue_en(issue_en), .bank_sel(bank_sel));

  typedef struct packed {
    logic       pol;
    logic       miss;
    logic       rv;
    logic [1:0] rt;
    logic [1:0] etid;
    logic       epul;
    logic       eiss;
    logic [3:0] req;
  } vec_t;

  // Miss-mode walk from reset; each row: inputs for one cycle, outputs after the edge.
  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,2'd0, 2'd0,1'b0,1'b1, 4'd4}, // R4 no miss, keep 0
    '{1'b1,1'b1,1'b0,2'd0, 2'd1,1'b1,1'b0, 4'd4}, // R4 miss on 0 -> 1
    '{1'b1,1'b0,1'b0,2'd0, 2'd1,1'b0,1'b0, 4'd5}, // R5 penalty
    '{1'b1,1'b0,1'b0,2'd0, 2'd1,1'b0,1'b0, 4'd5},
    '{1'b1,1'b0,1'b0,2'd0, 2'd1,1'b0,1'b1, 4'd5},
    '{1'b1,1'b1,1'b0,2'd0, 2'd2,1'b0,1'b0, 4'd6}, // placeholder fixed below
    '{1'b1,1'b1,1'b0,2'd0, 2'd2,1'b0,1'b0, 4'd9}, // R9 miss during stall
    '{1'b1,1'b0,1'b0,2'd0, 2'd2,1'b0,1'b0, 4'd5},
    '{1'b1,1'b0,1'b0,2'd0, 2'd2,1'b0,1'b1, 4'd9}, // R9 context 2 still ready
    '{1'b1,1'b1,1'b0,2'd0, 2'd3,1'b1,1'b0, 4'd6}, // R6 2 -> 3
    '{1'b1,1'b0,1'b0,2'd0, 2'd3,1'b0,1'b0, 4'd5},
    '{1'b1,1'b0,1'b0,2'd0, 2'd3,1'b0,1'b0, 4'd5},
    '{1'b1,1'b0,1'b0,2'd0, 2'd3,1'b0,1'b1, 4'd5},
    '{1'b1,1'b1,1'b0,2'd0, 2'd3,1'b0,1'b0, 4'd7}, // R7 all waiting, idle
    '{1'b1,1'b0,1'b0,2'd0, 2'd3,1'b0,1'b0, 4'd7},
    '{1'b1,1'b0,1'b1,2'd1, 2'd1,1'b1,1'b0, 4'd8}, // R8 refill 1 wakes
    '{1'b1,1'b0,1'b1,2'd3, 2'd1,1'b0,1'b0, 4'd5},
    '{1'b1,1'b0,1'b0,2'd0, 2'd1,1'b0,1'b0, 4'd5},
    '{1'b1,1'b0,1'b0,2'd0, 2'd1,1'b0,1'b1, 4'd5},
    '{1'b1,1'b1,1'b0,2'd0, 2'd3,1'b1,1'b0, 4'd6}, // R6 skip waiting 2
    '{1'b1,1'b0,1'b0,2'd0, 2'd3,1'b0,1'b0, 4'd5},
    '{1'b1,1'b0,1'b0,2'd0, 2'd3,1'b0,1'b0, 4'd5},
    '{1'b1,1'b0,1'b0,2'd0, 2'd3,1'b0,1'b1, 4'd5},
    '{1'b1,1'b1,1'b1,2'd3, 2'd3,1'b0,1'b0, 4'd7}, // R7 miss beats same refill
    '{1'b1,1'b0,1'b1,2'd3, 2'd3,1'b0,1'b1, 4'd8}, // R8 own refill, no pulse
    '{1'b0,1'b1,1'b0,2'd0, 2'd3,1'b0,1'b1, 4'd9}  // R9 miss in slice mode
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic pol, input logic miss, input logic rv,
                      input logic [1:0] rt);
    policy_sel   = pol;
    miss_valid   = miss;
    refill_valid = rv;
    refill_tid   = rt;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    policy_sel = 1'b0; miss_valid = 1'b0; refill_valid = 1'b0; refill_tid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Samples one time slice: stall cycles then issue cycles, until the next pulse.
  task automatic slice(output int lows, output int issues);
    lows = 0; issues = 0;
    for (int i = 0; i < 200; i++) begin
      if (i > 0 && switch_pulse) break;
      if (issue_en) issues++; else lows++;
      step(1'b0, 1'b0, 1'b0, 2'd0);
    end
  endtask

  initial begin
    #2_000_000;
    n_fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int lows, issues;
    bit seen;
    do_reset();
    // R1 reset state
    check(active_tid == 0 && !switch_pulse && issue_en, "R1",
          {active_tid, switch_pulse, issue_en}, 3'b001);
    check(bank_sel == 4'b0001, "R2", bank_sel, 1);

    for (int v = 0; v < NV; v++) begin
      vec_t r;
      logic [1:0] et;
      logic ep;
      r  = VECS[v];
      et = r.etid;
      ep = r.epul;
      if (v == 5) begin et = 2'd2; ep = 1'b1; end // R6 1 -> 2 with pulse
      step(r.pol, r.miss, r.rv, r.rt);
      check(active_tid == et && switch_pulse == ep && issue_en == r.eiss,
            $sformatf("R%0d row %0d", r.req, v),
            {active_tid, switch_pulse, issue_en}, {et, ep, r.eiss});
      check(bank_sel == (4'b0001 << et), "R2", bank_sel, 4'b0001 << et);
    end

    // R7: only context 3 ready in slice mode: no switch across slice ends
    for (int c = 0; c < 40; c++) begin
      step(1'b0, 1'b0, 1'b0, 2'd0);
      check(active_tid == 3 && !switch_pulse && issue_en, "R7",
            {active_tid, switch_pulse, issue_en}, 3'b111);
    end

    // R8/R6: refill context 1, the next slice end moves to 1
    step(1'b0, 1'b0, 1'b1, 2'd1);
    seen = switch_pulse;
    for (int c = 0; c < 40 && !seen; c++) begin
      step(1'b0, 1'b0, 1'b0, 2'd0);
      seen = switch_pulse;
    end
    check(seen && active_tid == 1, "R8", active_tid, 1);

    // R3/R5/R6: slice lengths and rotation from a fresh reset
    do_reset();
    check(active_tid == 0 && issue_en, "R1", active_tid, 0);
    slice(lows, issues);
    check(issues == QUANTUM, "R3", issues, QUANTUM);
    check(lows == 0, "R5", lows, 0);
    check(active_tid == 1, "R6", active_tid, 1);
    for (int s = 0; s < 3; s++) begin
      slice(lows, issues);
      check(issues == QUANTUM, "R3", issues, QUANTUM);
      check(lows == PENALTY + 1, "R5", lows, PENALTY + 1);
      check(active_tid == TID_W'(s + 2), "R6", active_tid, (s + 2) % NUM_CTX);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule